// File: doc/BRIEF.md
# Output-Pulled Cell Switch with Per-Destination Input Queues

This block is an N-port switch for fixed-size cells. All storage lives on the input side. Each input owns N partitions, one for each destination output. A cell that arrives on an input carries a destination tag and is filed into the matching partition. From the point of view of an output, the N partitions that hold cells for it form N virtual queues, one per input.

Movement across the shared backplane is driven by the outputs. A time-division schedule hands the single bus slot to one output per clock step. The output that holds the slot picks one of its virtual queues in rotating order and pulls the head cell. Because only one output reaches the bus in a given step, two inputs never compete for the same output, and no input-side arbiter exists. Each input partition also reports its occupancy and a full flag. Each input keeps a wrapping count of cells lost because their partition was full.

Top module: `vq_switch`

## Requirements
- R1: A cell presented on input i with destination d (d < N, field `in_dest[i*DW +: DW]`) is stored in partition (i,d). That partition's occupancy, reported at `occ[(i*N+d)*OW +: OW]`, rises by one after the clock edge.
- R2: Cells leave each partition (i,d) in the same order in which they were accepted.
- R3: The bus slot rotates through outputs 0,1,..,N-1, starting at output 0 in the first step after reset. A cell pulled in step k appears one cycle later on `out_data`, with only bit (k mod N) of `out_valid` set. At most one `out_valid` bit is ever high.
- R4: The output that holds the slot scans its virtual queues from its own pointer upward, wrapping, and skips empty ones. It serves the first eligible queue and then moves its pointer to the input after the one served. `out_src` reports the input served.
- R5: In a step where input i presents a cell, no cell is read from any partition of input i. The read waits for a later step.
- R6: A cell whose partition already holds DEPTH cells is discarded. The input's counter at `drop_cnt[i*DROPW +: DROPW]` rises by one, wrapping, and the partition's contents are unchanged.
- R7: `full[i*N+d]` is high exactly when partition (i,d) holds DEPTH cells.
- R8: After reset, all partitions are empty, all flags and counters are zero, no output is valid, and every round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Per-input cell present this step |
| in_dest | input | N*DW | Per-input destination output tag |
| in_data | input | N*CW | Per-input cell payload |
| out_valid | output | N | One-hot: output receiving a cell this cycle |
| out_data | output | CW | Cell carried on the backplane bus |
| out_src | output | DW | Input the delivered cell came from |
| occ | output | N*N*OW | Occupancy of every partition (i,d) |
| full | output | N*N | Full flag of every partition (i,d) |
| drop_cnt | output | N*DROPW | Per-input wrapping count of discarded cells |

## Verification
The conflict case is an input that receives a new cell in the same step in which the slot-holding output would otherwise pull from it. The bench holds one input busy with arrivals for several consecutive steps while that input's partition for an output is non-empty. It then confirms that no cell from that input reaches the bus inside the window, and that the cells do appear once the arrivals stop. A second overlap, an arrival into a full partition, is produced by back-to-back writes that cannot drain while the input stays busy. It is judged by the drop counter, the full flag and the absence of the discarded payloads from the output stream. A cycle-level reference model runs alongside the bench and compares every output, occupancy and counter after each step.

// File: rtl/vq_switch.sv
module vq_switch #(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter int CW    = 16,
  parameter int DROPW = 8,
  localparam int DW   = (N > 1) ? $clog2(N) : 1,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          in_valid,
  input  logic [N*DW-1:0]       in_dest,
  input  logic [N*CW-1:0]       in_data,
  output logic [N-1:0]          out_valid,
  output logic [CW-1:0]         out_data,
  output logic [DW-1:0]         out_src,
  output logic [N*N*OW-1:0]     occ,
  output logic [N*N-1:0]        full,
  output logic [N*DROPW-1:0]    drop_cnt
);
  localparam int NQ = N * N;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0]    mem [NQ*DEPTH];
  logic [PW-1:0]    wp  [NQ];
  logic [PW-1:0]    rp  [NQ];
  logic [OW-1:0]    cnt [NQ];
  logic [DW-1:0]    rr  [N];
  logic [DROPW-1:0] dc  [N];
  logic [DW-1:0]    slot;

  logic [N-1:0]  elig, drop;
  logic [NQ-1:0] push, pop;
  logic          hit;
  logic [DW-1:0] src;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb
    for (int i = 0; i < N; i++)
      elig[i] = (cnt[i*N + int'(slot)] != '0) && !in_valid[i];

  always_comb begin
    hit = 1'b0;
    src = '0;
    for (int k = 0; k < N; k++)
      if (!hit && elig[(int'(rr[slot]) + k) % N]) begin
        hit = 1'b1;
        src = DW'((int'(rr[slot]) + k) % N);
      end
  end

  always_comb
    for (int i = 0; i < N; i++) begin
      drop[i] = in_valid[i] && (cnt[i*N + int'(in_dest[i*DW +: DW])] == OW'(DEPTH));
      for (int d = 0; d < N; d++) begin
        push[i*N+d] = in_valid[i] && (in_dest[i*DW +: DW] == DW'(d)) &&
                      (cnt[i*N+d] != OW'(DEPTH));
        pop[i*N+d]  = hit && (src == DW'(i)) && (slot == DW'(d));
      end
    end

  always_ff @(posedge clk)
    for (int q = 0; q < NQ; q++)
      if (push[q]) mem[q*DEPTH + int'(wp[q])] <= in_data[(q/N)*CW +: CW];

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      out_valid <= '0;
      out_data  <= '0;
      out_src   <= '0;
      for (int q = 0; q < NQ; q++) begin
        wp[q]  <= '0;
        rp[q]  <= '0;
        cnt[q] <= '0;
      end
      for (int i = 0; i < N; i++) begin
        rr[i] <= '0;
        dc[i] <= '0;
      end
    end else begin
      slot      <= (slot == DW'(N - 1)) ? '0 : slot + DW'(1);
      out_valid <= hit ? (N'(1) << slot) : '0;
      if (hit) begin
        out_data <= mem[(int'(src)*N + int'(slot))*DEPTH + int'(rp[int'(src)*N + int'(slot)])];
        out_src  <= src;
        rr[slot] <= (src == DW'(N - 1)) ? '0 : src + DW'(1);
      end
      for (int q = 0; q < NQ; q++) begin
        if (push[q]) wp[q] <= bump(wp[q]);
        if (pop[q])  rp[q] <= bump(rp[q]);
        cnt[q] <= cnt[q] + OW'(push[q]) - OW'(pop[q]);
      end
      for (int i = 0; i < N; i++)
        if (drop[i]) dc[i] <= dc[i] + DROPW'(1);
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign occ[q*OW +: OW] = cnt[q];
    assign full[q]         = (cnt[q] == OW'(DEPTH));
  end
  for (genvar i = 0; i < N; i++) begin : g_i
    assign drop_cnt[i*DROPW +: DROPW] = dc[i];
  end
endmodule

// File: rtl/vq_switch_chk.sv
module vq_switch_chk #(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter int DROPW = 8,
  localparam int DW   = (N > 1) ? $clog2(N) : 1,
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic [N-1:0]       in_valid,
  input logic [N*DW-1:0]    in_dest,
  input logic [N-1:0]       out_valid,
  input logic [DW-1:0]      out_src,
  input logic [N*N*OW-1:0]  occ,
  input logic [N*N-1:0]     full,
  input logic [N*DROPW-1:0] drop_cnt
);
  logic [DW-1:0] ck_slot, ck_prev;
  logic [N-1:0]  prev_in;

  always_ff @(posedge clk)
    if (rst) begin
      ck_slot <= '0;
      ck_prev <= '0;
      prev_in <= '0;
    end else begin
      ck_slot <= (ck_slot == DW'(N - 1)) ? '0 : ck_slot + DW'(1);
      ck_prev <= ck_slot;
      prev_in <= in_valid;
    end

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst) $onehot0(out_valid)); // R3
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (out_valid & ~(N'(1) << ck_prev)) == '0); // R3
  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (|out_valid) |-> !prev_in[out_src]); // R5

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [DW-1:0] dst;
    assign dst = in_dest[i*DW +: DW];
    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (rst)
      (in_valid[i] && full[i*N + int'(dst)]) |=>
      drop_cnt[i*DROPW +: DROPW] == $past(drop_cnt[i*DROPW +: DROPW]) + DROPW'(1)); // R6
  end

  for (genvar q = 0; q < N*N; q++) begin : g_q
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
      occ[q*OW +: OW] <= OW'(DEPTH)); // R7
  end
endmodule

bind vq_switch vq_switch_chk #(.N(N), .DEPTH(DEPTH), .DROPW(DROPW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
  .out_valid(out_valid), .out_src(out_src), .occ(occ), .full(full),
  .drop_cnt(drop_cnt));

// File: tb/tb_vq_switch.sv
module tb_vq_switch;
  localparam int N = 4, DEPTH = 4, CW = 16, DROPW = 8, DW = 2, OW = 3;

  logic clk = 0, rst = 1;
  logic [N-1:0]       in_valid = '0;
  logic [N*DW-1:0]    in_dest  = '0;
  logic [N*CW-1:0]    in_data  = '0;
  logic [N-1:0]       out_valid;
  logic [CW-1:0]      out_data;
  logic [DW-1:0]      out_src;
  logic [N*N*OW-1:0]  occ;
  logic [N*N-1:0]     full;
  logic [N*DROPW-1:0] drop_cnt;

  vq_switch dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model
  int mq [N][N][DEPTH];
  int mc [N][N];
  int mrr[N];
  int mdrop[N];
  int mslot, edata, esrc, s, g, c, d;
  bit [N-1:0] ev;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        mrr[i] = 0; mdrop[i] = 0;
        for (int j = 0; j < N; j++) mc[i][j] = 0;
      end
      mslot = 0; ev = '0; edata = 0; esrc = 0;
    end else begin
      ev = '0; s = mslot; g = -1;
      for (int k = 0; k < N; k++) begin
        c = (mrr[s] + k) % N;
        if (g < 0 && mc[c][s] > 0 && !in_valid[c]) g = c;
      end
      if (g >= 0) begin
        ev[s] = 1'b1; edata = mq[g][s][0]; esrc = g;
        for (int k = 0; k < DEPTH - 1; k++) mq[g][s][k] = mq[g][s][k+1];
        mc[g][s]--;
        mrr[s] = (g + 1) % N;
      end
      for (int i = 0; i < N; i++)
        if (in_valid[i]) begin
          d = int'(in_dest[i*DW +: DW]);
          if (mc[i][d] == DEPTH) mdrop[i] = (mdrop[i] + 1) % 256;
          else begin mq[i][d][mc[i][d]] = int'(in_data[i*CW +: CW]); mc[i][d]++; end
        end
      mslot = (s + 1) % N;
    end
  end

  // per-cycle comparison and delivery log
  int log_src[4096], log_out[4096], log_dat[4096];
  int log_n = 0;

  always @(negedge clk) if (!rst) begin
    chk(out_valid == ev, "R3 out_valid", int'(out_valid), int'(ev));
    if (|ev) begin
      chk(int'(out_data) == edata, "R2 out_data", int'(out_data), edata);
      chk(int'(out_src) == esrc, "R4 out_src", int'(out_src), esrc);
    end
    for (int i = 0; i < N; i++) begin
      chk(int'(drop_cnt[i*DROPW +: DROPW]) == mdrop[i], "R6 drop_cnt",
          int'(drop_cnt[i*DROPW +: DROPW]), mdrop[i]);
      for (int j = 0; j < N; j++) begin
        chk(int'(occ[(i*N+j)*OW +: OW]) == mc[i][j], "R1 occ", int'(occ[(i*N+j)*OW +: OW]), mc[i][j]);
        chk(full[i*N+j] == (mc[i][j] == DEPTH), "R7 full", int'(full[i*N+j]), int'(mc[i][j] == DEPTH));
      end
    end
    if (|out_valid && log_n < 4096) begin
      for (int o = 0; o < N; o++) if (out_valid[o]) log_out[log_n] = o;
      log_src[log_n] = int'(out_src);
      log_dat[log_n] = int'(out_data);
      log_n++;
    end
  end

  task automatic put(input int i, input int dst, input int val);
    in_valid[i] = 1'b1;
    in_dest[i*DW +: DW] = DW'(dst);
    in_data[i*CW +: CW] = CW'(val);
  endtask

  task automatic tick();
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic t_reset();
    chk(out_valid == '0, "R8 out_valid", int'(out_valid), 0);
    chk(occ == '0, "R8 occ", int'(occ != '0), 0);
    chk(full == '0, "R8 full", int'(full), 0);
    chk(drop_cnt == '0, "R8 drop_cnt", int'(drop_cnt != '0), 0);
  endtask

  task automatic t_fifo();
    int base, got;
    base = log_n; got = 0;
    for (int k = 0; k < 3; k++) begin put(1, 2, 16'h1200 + k); tick(); end
    idle(20);
    for (int e = base; e < log_n; e++)
      if (log_src[e] == 1 && log_out[e] == 2) begin
        chk(log_dat[e] == 16'h1200 + got, "R2 fifo order", log_dat[e], 16'h1200 + got);
        got++;
      end
    chk(got == 3, "R2 fifo count", got, 3);
  endtask

  task automatic t_rr();
    int base, n, a, b, cc;
    base = log_n; n = 0; a = -1; b = -1; cc = -1;
    for (int k = 0; k < 2; k++) begin
      put(0, 0, 16'h0000 + k); put(1, 0, 16'h1000 + k); put(3, 0, 16'h3000 + k);
      tick();
    end
    idle(40);
    for (int e = base; e < log_n; e++)
      if (log_out[e] == 0) begin
        if (n == 0) a = log_src[e];
        if (n == 1) b = log_src[e];
        if (n == 2) cc = log_src[e];
        n++;
      end
    chk(n == 6, "R4 rr count", n, 6);
    chk(a != b && b != cc && a != cc && cc >= 0, "R4 rr rotation", cc, a);
  endtask

  task automatic t_collision();
    int base, hits, later;
    for (int k = 0; k < 2; k++) begin put(2, 0, 16'h2000 + k); tick(); end
    base = log_n; hits = 0;
    for (int k = 0; k < 8; k++) begin put(2, 3, 16'h2300 + k); tick(); end
    for (int e = base; e < log_n; e++) if (log_src[e] == 2) hits++;
    chk(hits == 0, "R5 no read while writing", hits, 0);
    base = log_n; later = 0;
    idle(30);
    for (int e = base; e < log_n; e++) if (log_src[e] == 2 && log_out[e] == 0) later++;
    chk(later == 2, "R5 deferred reads", later, 2);
  endtask

  task automatic t_overflow();
    int d0, base, seen;
    d0 = int'(drop_cnt[3*DROPW +: DROPW]);
    for (int k = 0; k < DEPTH + 2; k++) begin put(3, 1, 16'h3100 + k); tick(); end
    chk(int'(drop_cnt[3*DROPW +: DROPW]) == (d0 + 2) % 256, "R6 drops",
        int'(drop_cnt[3*DROPW +: DROPW]), (d0 + 2) % 256);
    chk(full[3*N+1] == 1'b1, "R7 full set", int'(full[3*N+1]), 1);
    chk(int'(occ[(3*N+1)*OW +: OW]) == DEPTH, "R1 occ at full", int'(occ[(3*N+1)*OW +: OW]), DEPTH);
    base = log_n; seen = 0;
    idle(30);
    for (int e = base; e < log_n; e++)
      if (log_src[e] == 3 && log_out[e] == 1) begin
        chk(log_dat[e] == 16'h3100 + seen, "R6 kept cells", log_dat[e], 16'h3100 + seen);
        seen++;
      end
    chk(seen == DEPTH, "R6 dropped cells absent", seen, DEPTH);
    chk(full[3*N+1] == 1'b0, "R7 full clear", int'(full[3*N+1]), 0);
  endtask

  task automatic t_stress();
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int t = 0; t < 1500; t++) begin
      for (int i = 0; i < N; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[0]) put(i, int'(lf[5:4]), int'({lf[11:8], 12'(t)}));
      end
      tick();
    end
    idle(100);
    chk(occ == '0, "R1 drained", int'(occ != '0), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_fifo();
    t_rr();
    t_collision();
    t_overflow();
    t_stress();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule